// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the software-visible control state of one channel of a bus-master DMA disk interface: an 8-bit command byte, an 8-bit status byte and a 32-bit pointer to the descriptor table in memory. Software reaches it through a byte-addressed register port. Each access carries a write flag, a 3-bit offset and a size code. When software flips the start/stop bit of the command byte, the block tells the device side to begin or to abandon a transfer. When the device side reports completion, an error or an interrupt, the block records it in the status byte.

A two-state machine tracks the transfer. In `XF_IDLE` no transfer is running. The transition *launch* (IDLE to RUN) happens when a command write sets the start bit while a device is present. The transition *abort* (RUN to IDLE) happens when a command write clears the start bit while a device is present. The transition *finish* (RUN to IDLE) happens on a completion report. The self-loop *refuse* covers a start/stop change requested with no device present: the state stays where it is and an error is flagged. In `XF_RUN` a transfer is in flight. The status active bit and the command start bit both read back as "state is RUN".

Top module: `bmi_channel_regs`

## Requirements
- R1: After reset, a 4-byte read at offset 0 returns 0x0060_0000, so the command byte is 0 and the status byte is 0x60 (bits 5 and 6 set). The pointer reads 0 and all pulse outputs are low.
- R2: The register window is little-endian. Byte 0 is the command, byte 2 is the status, and bytes 4 to 7 are the pointer. Bytes 1 and 3 read as zero, and writes to them are ignored without error. Size code 0, 1 and 2 means 1, 2 and 4 bytes. A read returns that many bytes starting at the offset, zero-extended.
- R3: In IDLE with a device present, a 1-byte command write with bit 0 set moves to RUN. In the cycle after the write, `dma_start_o` pulses for one cycle, `dma_ptr_o` carries the pointer value, and status bit 0 and command bit 0 read 1.
- R4: In RUN with a device present, a 1-byte command write with bit 0 clear returns to IDLE. In the cycle after the write, `dma_abort_o` pulses for one cycle, and status bit 0 and command bit 0 read 0.
- R5: Status bit 0 (active) is read-only, and status writes never change it.
- R6: Status bit 2 (interrupt) and bit 1 (DMA error) are write-1-to-clear. Writing 0 keeps them. Writing 1 to a bit that is already clear leaves it clear.
- R7: `dma_done_i` clears the start bit and the active bit, sets the interrupt bit, and gives no abort pulse. It takes priority over a command write in the same cycle. `intr_post_i` sets the interrupt bit, and `dev_err_i` sets the error bit. A hardware set wins over a software clear in the same cycle.
- R8: The pointer is written only by a 4-byte write at offset 4, and its bits [1:0] are stored as zero.
- R9: `size_err_o` pulses in the cycle after a write of the wrong size. The wrong sizes are any size other than 1 byte at offset 0 or 2, and any size other than 4 bytes at offset 4. The register that was addressed keeps its value.
- R10: A command write that would change the start bit while `dev_present` is low pulses `nodev_err_o` in the following cycle. It leaves the state unchanged and still stores command bits 7:1.
- R11: Command bits 7:1, including the direction bit 3, store the written value. A command write that repeats the current start bit gives neither a start pulse nor an abort pulse.
- R12: Status bits 7:3, including the capability bits 5 and 6, store the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Byte offset in the window |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| acc_wdata | input | 32 | Write data, least significant byte first |
| acc_rdata | output | 32 | Read data for the current offset and size |
| dev_present | input | 1 | A device is selected on this channel |
| dma_done_i | input | 1 | Device reports transfer complete |
| intr_post_i | input | 1 | Device posts an interrupt |
| dev_err_i | input | 1 | Device reports a DMA error |
| dma_start_o | output | 1 | One-cycle transfer start pulse |
| dma_abort_o | output | 1 | One-cycle transfer abort pulse |
| dma_ptr_o | output | 32 | Descriptor pointer captured at launch |
| size_err_o | output | 1 | Write with an illegal size |
| nodev_err_o | output | 1 | Start/stop change refused, no device |

## Verification
The assertions check on every cycle the properties that hold over a single edge:
- start and abort are never high together;
- an abort pulse only follows a cycle in RUN, and a start pulse only comes with entry to RUN;
- a refused request leaves the state unchanged;
- an interrupt or error bit survives any cycle with no matching clear;
- a hardware set always lands;
- the pointer is untouched when a size error is flagged.

The bench scenarios show the rest, which needs a sequence of accesses:
- the byte layout and zero-extension of reads;
- the write-1-to-clear cases on bits that are set and on bits that are clear;
- the pointer value carried at launch;
- completion beating a same-cycle command write;
- a set beating a same-cycle clear.

// File: rtl/bmi_pkg.sv
`timescale 1ns/1ps
package bmi_pkg;
    typedef enum logic {XF_IDLE = 1'b0, XF_RUN = 1'b1} xfer_state_t;

    localparam int unsigned OFS_W  = 3;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;

    localparam logic [OFS_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd2;
    localparam logic [OFS_W-1:0] OFS_PTR  = 3'd4;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int unsigned CMD_GO  = 0;
    localparam int unsigned ST_ACT  = 0;
    localparam int unsigned ST_ERR  = 1;
    localparam int unsigned ST_INT  = 2;
    localparam int unsigned PTR_LOW = 2;

    localparam logic [BYTE_W-1:0] ST_RESET = 8'h60;
endpackage

// File: rtl/bmi_acc_dec.sv
`timescale 1ns/1ps
module bmi_acc_dec
    import bmi_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [OFS_W-1:0] acc_addr,
    input  logic [1:0]       acc_size,
    output logic             cmd_we,
    output logic             st_we,
    output logic             ptr_we,
    output logic             size_bad
);
    logic wr;
    logic hit_cmd, hit_st, hit_ptr;

    always_comb begin
        wr       = acc_valid && acc_write;
        hit_cmd  = wr && (acc_addr == OFS_CMD);
        hit_st   = wr && (acc_addr == OFS_STAT);
        hit_ptr  = wr && (acc_addr == OFS_PTR);
        cmd_we   = hit_cmd && (acc_size == SZ_BYTE);
        st_we    = hit_st  && (acc_size == SZ_BYTE);
        ptr_we   = hit_ptr && (acc_size == SZ_WORD);
        size_bad = ((hit_cmd || hit_st) && (acc_size != SZ_BYTE)) ||
                   (hit_ptr && (acc_size != SZ_WORD));
    end
endmodule

// File: rtl/bmi_xfer_fsm.sv
`timescale 1ns/1ps
module bmi_xfer_fsm
    import bmi_pkg::*;
#(
    parameter int unsigned PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic             go_bit,
    input  logic             dev_present,
    input  logic             dma_done,
    input  logic [PTR_W-1:0] ptr_cur,
    output logic             run,
    output logic             dma_start,
    output logic             dma_abort,
    output logic             nodev_err,
    output logic [PTR_W-1:0] dma_ptr
);
    xfer_state_t state_q, state_d;
    logic launch, stop, refuse;

    // next state: launch, abort, finish, refuse
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        stop    = 1'b0;
        refuse  = 1'b0;
        unique case (state_q)
            XF_IDLE: begin
                if (!dma_done && cmd_we && go_bit) begin
                    if (dev_present) begin
                        state_d = XF_RUN;
                        launch  = 1'b1;
                    end else begin
                        refuse = 1'b1;
                    end
                end
            end
            XF_RUN: begin
                if (dma_done) begin
                    state_d = XF_IDLE;
                end else if (cmd_we && !go_bit) begin
                    if (dev_present) begin
                        state_d = XF_IDLE;
                        stop    = 1'b1;
                    end else begin
                        refuse = 1'b1;
                    end
                end
            end
            default: state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start <= 1'b0;
            dma_abort <= 1'b0;
            nodev_err <= 1'b0;
            dma_ptr   <= '0;
        end else begin
            dma_start <= launch;
            dma_abort <= stop;
            nodev_err <= refuse;
            if (launch) dma_ptr <= ptr_cur;
        end
    end

    assign run = (state_q == XF_RUN);

    a_r3_start_enters_run: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (run && !$past(run)));
    a_r4_abort_leaves_run: assert property (@(posedge clk) disable iff (!rst_n)
        dma_abort |-> (!run && $past(run)));
    a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_start, dma_abort}));
    a_r10_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        nodev_err |-> (run == $past(run)));
    a_r7_done_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> (!run && !dma_abort));
endmodule

// File: rtl/bmi_stat_reg.sv
`timescale 1ns/1ps
module bmi_stat_reg
    import bmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_we,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              run,
    input  logic              set_int,
    input  logic              set_err,
    output logic [BYTE_W-1:0] stat
);
    localparam int unsigned MISC_W = BYTE_W - 3;

    logic [MISC_W-1:0] misc_q;
    logic              int_q, err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misc_q <= ST_RESET[BYTE_W-1:3];
            int_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (st_we) misc_q <= wbyte[BYTE_W-1:3];
            if (set_int)                     int_q <= 1'b1;
            else if (st_we && wbyte[ST_INT]) int_q <= 1'b0;
            if (set_err)                     err_q <= 1'b1;
            else if (st_we && wbyte[ST_ERR]) err_q <= 1'b0;
        end
    end

    assign stat = {misc_q, int_q, err_q, run};

    a_r6_int_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (int_q && !(st_we && wbyte[ST_INT])) |=> int_q);
    a_r6_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(st_we && wbyte[ST_ERR])) |=> err_q);
    a_r7_int_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_int |=> int_q);
    a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err_q);
endmodule

// File: rtl/bmi_channel_regs.sv
`timescale 1ns/1ps
module bmi_channel_regs
    import bmi_pkg::*;
#(
    parameter int unsigned PTR_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic [WORD_W-1:0] acc_rdata,
    input  logic              dev_present,
    input  logic              dma_done_i,
    input  logic              intr_post_i,
    input  logic              dev_err_i,
    output logic              dma_start_o,
    output logic              dma_abort_o,
    output logic [PTR_W-1:0]  dma_ptr_o,
    output logic              size_err_o,
    output logic              nodev_err_o
);
    localparam int unsigned IMG_W = 2 * WORD_W;

    logic              cmd_we, st_we, ptr_we, size_bad;
    logic              run;
    logic [BYTE_W-1:1] cmd_hi_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [BYTE_W-1:0] stat, cmd_rd;
    logic [IMG_W-1:0]  img, shifted;
    logic [WORD_W-1:0] rmask;

    bmi_acc_dec u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .cmd_we    (cmd_we),
        .st_we     (st_we),
        .ptr_we    (ptr_we),
        .size_bad  (size_bad)
    );

    bmi_xfer_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .go_bit      (acc_wdata[CMD_GO]),
        .dev_present (dev_present),
        .dma_done    (dma_done_i),
        .ptr_cur     (ptr_q),
        .run         (run),
        .dma_start   (dma_start_o),
        .dma_abort   (dma_abort_o),
        .nodev_err   (nodev_err_o),
        .dma_ptr     (dma_ptr_o)
    );

    bmi_stat_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_we   (st_we),
        .wbyte   (acc_wdata[BYTE_W-1:0]),
        .run     (run),
        .set_int (intr_post_i || dma_done_i),
        .set_err (dev_err_i),
        .stat    (stat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_hi_q   <= '0;
            ptr_q      <= '0;
            size_err_o <= 1'b0;
        end else begin
            size_err_o <= size_bad;
            if (cmd_we) cmd_hi_q <= acc_wdata[BYTE_W-1:1];
            if (ptr_we) ptr_q <= {acc_wdata[PTR_W-1:PTR_LOW], {PTR_LOW{1'b0}}};
        end
    end

    always_comb begin
        cmd_rd  = {cmd_hi_q, run};
        img     = '0;
        img[BYTE_W-1:0]                      = cmd_rd;
        img[2*BYTE_W +: BYTE_W]              = stat;
        img[OFS_PTR*BYTE_W +: PTR_W]         = ptr_q;
        shifted = img >> {acc_addr, 3'b000};
        unique case (acc_size)
            SZ_BYTE: rmask = 32'h0000_00FF;
            SZ_HALF: rmask = 32'h0000_FFFF;
            default: rmask = 32'hFFFF_FFFF;
        endcase
        acc_rdata = shifted[WORD_W-1:0] & rmask;
    end

    a_r3_ptr_carried: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start_o |-> (dma_ptr_o == $past(ptr_q)));
    a_r9_ptr_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        size_err_o |-> (ptr_q == $past(ptr_q)));
    a_r5_active_tracks_go: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !dma_done_i && !cmd_we) |=> (stat[ST_ACT] == $past(stat[ST_ACT])));
endmodule

// File: tb/test_bmi_channel_regs.sv
`timescale 1ns/1ps
module test_bmi_channel_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        dev_present = 1'b0, dma_done_i = 1'b0, intr_post_i = 1'b0, dev_err_i = 1'b0;
    logic        dma_start_o, dma_abort_o, size_err_o, nodev_err_o;
    logic [31:0] dma_ptr_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bmi_channel_regs i_bmi_channel_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .dev_present(dev_present), .dma_done_i(dma_done_i),
        .intr_post_i(intr_post_i), .dev_err_i(dev_err_i), .dma_start_o(dma_start_o),
        .dma_abort_o(dma_abort_o), .dma_ptr_o(dma_ptr_o), .size_err_o(size_err_o),
        .nodev_err_o(nodev_err_o)
    );

    // {write, addr, size, wdata, expected read}
    localparam int NV = 18;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 3'd4, 2'd2, 32'h1234_5677, 32'h0},
        {1'b0, 3'd4, 2'd2, 32'h0, 32'h1234_5674},
        {1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_0060},
        {1'b0, 3'd1, 2'd1, 32'h0, 32'h0000_6000},
        {1'b0, 3'd4, 2'd1, 32'h0, 32'h0000_5674},
        {1'b0, 3'd6, 2'd1, 32'h0, 32'h0000_1234},
        {1'b1, 3'd0, 2'd0, 32'h08, 32'h0},
        {1'b0, 3'd0, 2'd0, 32'h0, 32'h0000_0008},
        {1'b1, 3'd2, 2'd0, 32'h00, 32'h0},
        {1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_0000},
        {1'b1, 3'd2, 2'd0, 32'h60, 32'h0},
        {1'b1, 3'd0, 2'd0, 32'h00, 32'h0},
        {1'b1, 3'd1, 2'd0, 32'hFF, 32'h0},
        {1'b0, 3'd0, 2'd2, 32'h0, 32'h0060_0000},
        {1'b1, 3'd4, 2'd2, 32'h0000_0003, 32'h0},
        {1'b0, 3'd4, 2'd2, 32'h0, 32'h0000_0000},
        {1'b1, 3'd4, 2'd2, 32'h1234_5677, 32'h0},
        {1'b0, 3'd0, 2'd2, 32'h0, 32'h0060_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = s;
        #1 d = acc_rdata;
        acc_valid = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements): actual hang expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 2'd2, d); chk("R1 reset cmd/status", d, 32'h0060_0000);
        rd(3'd4, 2'd2, d); chk("R1 reset pointer", d, 32'h0);
        chk("R1 reset pulses", {28'h0, dma_start_o, dma_abort_o, size_err_o, nodev_err_o}, 32'h0);

        // R2 R8 R11 R12 register map table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][69]) wr(VEC[i][68:66], VEC[i][65:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][68:66], VEC[i][65:64], d);
                chk($sformatf("R2 R8 R11 R12 table[%0d]", i), d, VEC[i][31:0]);
            end
        end

        // R9 bad sizes
        wr(3'd0, 2'd1, 32'h0001);
        chk("R9 cmd half write flags", {31'h0, size_err_o}, 32'h1);
        chk("R9 cmd half write no start", {31'h0, dma_start_o}, 32'h0);
        rd(3'd0, 2'd0, d); chk("R9 cmd unchanged", d, 32'h0);
        wr(3'd4, 2'd0, 32'hFF);
        chk("R9 ptr byte write flags", {31'h0, size_err_o}, 32'h1);
        rd(3'd4, 2'd2, d); chk("R9 ptr unchanged", d, 32'h1234_5674);

        // R3 launch
        dev_present = 1'b1;
        wr(3'd0, 2'd0, 32'h01);
        chk("R3 start pulse", {31'h0, dma_start_o}, 32'h1);
        chk("R3 pointer carried", dma_ptr_o, 32'h1234_5674);
        chk("R3 no abort", {31'h0, dma_abort_o}, 32'h0);
        rd(3'd0, 2'd2, d); chk("R3 active and go set", d, 32'h0061_0001);
        @(negedge clk);
        chk("R3 start one cycle", {31'h0, dma_start_o}, 32'h0);

        // R11 same go value, direction bit
        wr(3'd0, 2'd0, 32'h09);
        chk("R11 no pulse on repeat", {30'h0, dma_start_o, dma_abort_o}, 32'h0);
        rd(3'd0, 2'd0, d); chk("R11 direction stored", d, 32'h09);

        // R5 active read-only
        wr(3'd2, 2'd0, 32'h60);
        rd(3'd2, 2'd0, d); chk("R5 active kept", d, 32'h61);

        // R4 abort
        wr(3'd0, 2'd0, 32'h08);
        chk("R4 abort pulse", {31'h0, dma_abort_o}, 32'h1);
        chk("R4 no start", {31'h0, dma_start_o}, 32'h0);
        rd(3'd0, 2'd2, d); chk("R4 active cleared", d, 32'h0060_0008);
        @(negedge clk);
        chk("R4 abort one cycle", {31'h0, dma_abort_o}, 32'h0);

        // R10 no device
        dev_present = 1'b0;
        wr(3'd0, 2'd0, 32'h0B);
        chk("R10 nodev flagged", {31'h0, nodev_err_o}, 32'h1);
        chk("R10 no start", {31'h0, dma_start_o}, 32'h0);
        rd(3'd0, 2'd2, d); chk("R10 state kept, bits stored", d, 32'h0060_000A);
        dev_present = 1'b1;

        // R7 completion
        wr(3'd0, 2'd0, 32'h01);
        chk("R7 relaunch", {31'h0, dma_start_o}, 32'h1);
        @(negedge clk); dma_done_i = 1'b1;
        @(negedge clk); dma_done_i = 1'b0;
        chk("R7 done no abort", {31'h0, dma_abort_o}, 32'h0);
        rd(3'd0, 2'd2, d); chk("R7 done clears go, sets int", d, 32'h0064_0000);

        // R6 write-1-to-clear
        wr(3'd2, 2'd0, 32'h60);
        rd(3'd2, 2'd0, d); chk("R6 int kept on 0", d, 32'h64);
        wr(3'd2, 2'd0, 32'h64);
        rd(3'd2, 2'd0, d); chk("R6 int cleared", d, 32'h60);
        wr(3'd2, 2'd0, 32'h64);
        rd(3'd2, 2'd0, d); chk("R6 clear bit stays clear", d, 32'h60);
        @(negedge clk); dev_err_i = 1'b1;
        @(negedge clk); dev_err_i = 1'b0;
        rd(3'd2, 2'd0, d); chk("R7 error set", d, 32'h62);
        wr(3'd2, 2'd0, 32'h60);
        rd(3'd2, 2'd0, d); chk("R6 err kept on 0", d, 32'h62);
        wr(3'd2, 2'd0, 32'h62);
        rd(3'd2, 2'd0, d); chk("R6 err cleared", d, 32'h60);

        // R7 set beats clear in the same cycle
        @(negedge clk);
        intr_post_i = 1'b1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 3'd2; acc_size = 2'd0; acc_wdata = 32'h64;
        @(negedge clk);
        intr_post_i = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        rd(3'd2, 2'd0, d); chk("R7 post wins over clear", d, 32'h64);
        wr(3'd2, 2'd0, 32'h64);

        // R7 done beats abort in the same cycle
        wr(3'd0, 2'd0, 32'h01);
        @(negedge clk);
        dma_done_i = 1'b1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 3'd0; acc_size = 2'd0; acc_wdata = 32'h00;
        @(negedge clk);
        dma_done_i = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        chk("R7 done over abort", {31'h0, dma_abort_o}, 32'h0);
        rd(3'd0, 2'd2, d); chk("R7 finish state", d, 32'h0064_0000);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule